// File: doc/BRIEF.md
# Staged Control Bundle Pipeline

This block turns a 6-bit primary opcode, seen in the decode stage, into the nine control lines of a classic five-stage integer pipeline. It sorts them into three bundles: the execute bundle (destination select, immediate operand select, two-bit ALU operation), the memory bundle (branch, memory read, memory write) and the write-back bundle (register write, load-result select). It then carries them through three stage registers. Each register keeps only the bundles that later stages still need. The decode-to-execute register holds all three bundles, the execute-to-memory register holds memory and write-back, and the memory-to-write-back register holds write-back alone.

The two candidate destination register indices of the instruction travel with it. The execute stage picks one of them with the destination-select line. The chosen index then follows the write-back bundle to the end of the pipe. The ALU zero flag, presented during execute, is latched beside the memory bundle. The branch-taken signal is formed from that latched flag in the memory stage.

A stall places an all-zero bubble into the decode-to-execute register and lets the older stages move on. A flush places bubbles into the decode-to-execute and execute-to-memory registers. A synchronous reset clears everything.

Top module: `pipe_ctrl_chain`

## Requirements
- R1: Opcode 0x00 yields, one clock later at the execute outputs, dst_sel=1, alu_op=2'b10, alu_imm=0. Its memory bundle is all zero and its write-back bundle has reg_write=1, mem_to_reg=0.
- R2: Opcode 0x23 yields alu_imm=1, dst_sel=0, alu_op=2'b00, mem_read=1, mem_write=0, branch=0, reg_write=1, mem_to_reg=1.
- R3: Opcode 0x2B yields alu_imm=1, mem_write=1, and every other control line 0.
- R4: Opcode 0x04 yields branch=1, alu_op=2'b01, and every other control line 0.
- R5: Any other opcode yields all nine control lines 0.
- R6: The execute bundle appears one clock after the opcode is presented, the memory bundle two clocks after, and the write-back bundle three clocks after. Each bundle keeps its values unchanged while it moves along.
- R7: The memory-stage destination index equals rd_idx when the instruction's dst_sel is 1, and rt_idx otherwise. The indices are sampled together with the opcode. The same index appears at the write-back stage one clock later.
- R8: mem_pcsrc is 1 exactly when the memory-stage branch line is 1 and the alu_zero value sampled while that instruction was in execute was 1.
- R9: When stall is 1 at a clock edge, the decode-to-execute register loads all-zero control and zero indices. The execute-to-memory and memory-to-write-back registers advance normally.
- R10: When flush is 1 at a clock edge, both the decode-to-execute and execute-to-memory registers load all-zero control, indices and zero flag. The memory-to-write-back register advances normally.
- R11: When rst is 1 at a clock edge, every stage register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the instruction in decode |
| rt_idx | input | 5 | First destination candidate (instruction bits 20-16) |
| rd_idx | input | 5 | Second destination candidate (instruction bits 15-11) |
| stall | input | 1 | Insert a bubble into the execute stage |
| flush | input | 1 | Insert bubbles into the execute and memory stages |
| alu_zero | input | 1 | ALU zero flag of the instruction now in execute |
| ex_dst_sel | output | 1 | Execute stage: choose rd_idx as destination |
| ex_alu_imm | output | 1 | Execute stage: second ALU operand is the immediate |
| ex_alu_op | output | 2 | Execute stage: ALU operation class |
| mem_branch | output | 1 | Memory stage: instruction is a conditional branch |
| mem_read | output | 1 | Memory stage: data memory read |
| mem_write | output | 1 | Memory stage: data memory write |
| mem_pcsrc | output | 1 | Memory stage: branch taken |
| mem_dest | output | 5 | Memory stage: selected destination index |
| wb_reg_write | output | 1 | Write-back stage: register file write enable |
| wb_mem_to_reg | output | 1 | Write-back stage: write the loaded value |
| wb_dest | output | 5 | Write-back stage: destination index |

## Verification
The hardest case to reach is a taken branch that meets a flush or stall while other instructions are still in flight. The bubble must land in exactly the intended registers and leave the older instruction untouched. Each control line must keep its exact cycle offset behind its instruction, and mem_pcsrc must use the zero flag of the branch and not of a neighbour. The stimulus runs directed sequences that put a branch with zero=1 right next to stall, flush and both together. A long pseudo-random run then mixes all opcodes, indices, zero values, stalls and flushes, and one reset lands mid-stream. A behavioural model in the bench is compared against every output on every clock.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int OPC_W   = 6;
  localparam int ALUOP_W = 2;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;

  localparam logic [ALUOP_W-1:0] ALU_ADD  = 2'b00;
  localparam logic [ALUOP_W-1:0] ALU_SUB  = 2'b01;
  localparam logic [ALUOP_W-1:0] ALU_FUNC = 2'b10;

  typedef struct packed {
    logic               dst_sel;
    logic               alu_imm;
    logic [ALUOP_W-1:0] alu_op;
  } ex_ctl_t;

  typedef struct packed {
    logic branch;
    logic mrd;
    logic mwr;
  } mem_ctl_t;

  typedef struct packed {
    logic rwr;
    logic m2r;
  } wb_ctl_t;

  localparam ex_ctl_t  EX_NOP  = '0;
  localparam mem_ctl_t MEM_NOP = '0;
  localparam wb_ctl_t  WB_NOP  = '0;
endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ex_ctl_t          ex_o,
  output mem_ctl_t         mem_o,
  output wb_ctl_t          wb_o
);
  always_comb begin
    ex_o  = EX_NOP;
    mem_o = MEM_NOP;
    wb_o  = WB_NOP;
    unique case (opcode)
      OPC_RTYPE: begin
        ex_o.dst_sel = 1'b1;
        ex_o.alu_op  = ALU_FUNC;
        wb_o.rwr     = 1'b1;
      end
      OPC_LOAD: begin
        ex_o.alu_imm = 1'b1;
        ex_o.alu_op  = ALU_ADD;
        mem_o.mrd    = 1'b1;
        wb_o.rwr     = 1'b1;
        wb_o.m2r     = 1'b1;
      end
      OPC_STORE: begin
        ex_o.alu_imm = 1'b1;
        ex_o.alu_op  = ALU_ADD;
        mem_o.mwr    = 1'b1;
      end
      OPC_BEQ: begin
        ex_o.alu_op  = ALU_SUB;
        mem_o.branch = 1'b1;
      end
      default: ;
    endcase
  end

  // R2 R3: a memory access is either a read or a write, never both
  always_comb begin
    assert_no_rdwr_R3: assert (!(mem_o.mrd && mem_o.mwr));
  end
endmodule

// File: rtl/idex_stage.sv
module idex_stage
  import ctrl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bubble,
  input  ex_ctl_t          ex_d,
  input  mem_ctl_t         mem_d,
  input  wb_ctl_t          wb_d,
  input  logic [IDX_W-1:0] rt_d,
  input  logic [IDX_W-1:0] rd_d,
  output ex_ctl_t          ex_q,
  output mem_ctl_t         mem_q,
  output wb_ctl_t          wb_q,
  output logic [IDX_W-1:0] rt_q,
  output logic [IDX_W-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst || bubble) begin
      ex_q  <= EX_NOP;
      mem_q <= MEM_NOP;
      wb_q  <= WB_NOP;
      rt_q  <= '0;
      rd_q  <= '0;
    end else begin
      ex_q  <= ex_d;
      mem_q <= mem_d;
      wb_q  <= wb_d;
      rt_q  <= rt_d;
      rd_q  <= rd_d;
    end
  end

  // R9: a stall or flush leaves an all-zero bubble in execute
  assert_bubble_R9: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (ex_q == EX_NOP && mem_q == MEM_NOP && wb_q == WB_NOP));

  // R6: without a bubble the decoded bundles are taken over unchanged
  assert_ex_follow_R6: assert property (@(posedge clk) disable iff (rst)
    !bubble |=> (ex_q == $past(ex_d) && mem_q == $past(mem_d) && wb_q == $past(wb_d)));

  // R11: reset clears the register
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (ex_q == EX_NOP && mem_q == MEM_NOP && wb_q == WB_NOP));
endmodule

// File: rtl/exmem_stage.sv
module exmem_stage
  import ctrl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             dst_sel,
  input  mem_ctl_t         mem_d,
  input  wb_ctl_t          wb_d,
  input  logic [IDX_W-1:0] rt_d,
  input  logic [IDX_W-1:0] rd_d,
  input  logic             zero_d,
  output mem_ctl_t         mem_q,
  output wb_ctl_t          wb_q,
  output logic [IDX_W-1:0] dest_q,
  output logic             pcsrc
);
  logic [IDX_W-1:0] dest_sel;
  logic             zero_q;

  assign dest_sel = dst_sel ? rd_d : rt_d;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      mem_q  <= MEM_NOP;
      wb_q   <= WB_NOP;
      dest_q <= '0;
      zero_q <= 1'b0;
    end else begin
      mem_q  <= mem_d;
      wb_q   <= wb_d;
      dest_q <= dest_sel;
      zero_q <= zero_d;
    end
  end

  assign pcsrc = mem_q.branch & zero_q;

  // R8: a taken branch requires a branch in the memory stage
  assert_pcsrc_branch_R8: assert property (@(posedge clk) disable iff (rst)
    pcsrc |-> mem_q.branch);

  // R8: a branch with zero seen in execute is taken one stage later
  assert_pcsrc_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (!flush && mem_d.branch && zero_d) |=> pcsrc);

  // R7: destination chosen by the select line
  assert_dest_rd_R7: assert property (@(posedge clk) disable iff (rst)
    (!flush && dst_sel) |=> dest_q == $past(rd_d));
  assert_dest_rt_R7: assert property (@(posedge clk) disable iff (rst)
    (!flush && !dst_sel) |=> dest_q == $past(rt_d));

  // R10: flush empties the memory stage
  assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (mem_q == MEM_NOP && wb_q == WB_NOP && !pcsrc));

  // R6: bundles move on untouched
  assert_mem_follow_R6: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (mem_q == $past(mem_d) && wb_q == $past(wb_d)));
endmodule

// File: rtl/memwb_stage.sv
module memwb_stage
  import ctrl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  wb_ctl_t          wb_d,
  input  logic [IDX_W-1:0] dest_d,
  output wb_ctl_t          wb_q,
  output logic [IDX_W-1:0] dest_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_q   <= WB_NOP;
      dest_q <= '0;
    end else begin
      wb_q   <= wb_d;
      dest_q <= dest_d;
    end
  end

  // R6 R7: write-back bundle and index follow one clock behind memory
  assert_wb_follow_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wb_q == $past(wb_d) && dest_q == $past(dest_d)));
endmodule

// File: rtl/pipe_ctrl_chain.sv
module pipe_ctrl_chain
  import ctrl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [IDX_W-1:0]   rt_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               stall,
  input  logic               flush,
  input  logic               alu_zero,
  output logic               ex_dst_sel,
  output logic               ex_alu_imm,
  output logic [ALUOP_W-1:0] ex_alu_op,
  output logic               mem_branch,
  output logic               mem_read,
  output logic               mem_write,
  output logic               mem_pcsrc,
  output logic [IDX_W-1:0]   mem_dest,
  output logic               wb_reg_write,
  output logic               wb_mem_to_reg,
  output logic [IDX_W-1:0]   wb_dest
);
  ex_ctl_t          dec_ex;
  mem_ctl_t         dec_mem;
  wb_ctl_t          dec_wb;
  ex_ctl_t          x_ex;
  mem_ctl_t         x_mem;
  wb_ctl_t          x_wb;
  logic [IDX_W-1:0] x_rt;
  logic [IDX_W-1:0] x_rd;
  mem_ctl_t         m_mem;
  wb_ctl_t          m_wb;
  logic [IDX_W-1:0] m_dest;
  wb_ctl_t          w_wb;
  logic [IDX_W-1:0] w_dest;

  ctrl_decode u_dec (
    .opcode (opcode),
    .ex_o   (dec_ex),
    .mem_o  (dec_mem),
    .wb_o   (dec_wb)
  );

  idex_stage #(.IDX_W(IDX_W)) u_idex (
    .clk    (clk),
    .rst    (rst),
    .bubble (stall | flush),
    .ex_d   (dec_ex),
    .mem_d  (dec_mem),
    .wb_d   (dec_wb),
    .rt_d   (rt_idx),
    .rd_d   (rd_idx),
    .ex_q   (x_ex),
    .mem_q  (x_mem),
    .wb_q   (x_wb),
    .rt_q   (x_rt),
    .rd_q   (x_rd)
  );

  exmem_stage #(.IDX_W(IDX_W)) u_exmem (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .dst_sel (x_ex.dst_sel),
    .mem_d   (x_mem),
    .wb_d    (x_wb),
    .rt_d    (x_rt),
    .rd_d    (x_rd),
    .zero_d  (alu_zero),
    .mem_q   (m_mem),
    .wb_q    (m_wb),
    .dest_q  (m_dest),
    .pcsrc   (mem_pcsrc)
  );

  memwb_stage #(.IDX_W(IDX_W)) u_memwb (
    .clk    (clk),
    .rst    (rst),
    .wb_d   (m_wb),
    .dest_d (m_dest),
    .wb_q   (w_wb),
    .dest_q (w_dest)
  );

  assign ex_dst_sel    = x_ex.dst_sel;
  assign ex_alu_imm    = x_ex.alu_imm;
  assign ex_alu_op     = x_ex.alu_op;
  assign mem_branch    = m_mem.branch;
  assign mem_read      = m_mem.mrd;
  assign mem_write     = m_mem.mwr;
  assign mem_dest      = m_dest;
  assign wb_reg_write  = w_wb.rwr;
  assign wb_mem_to_reg = w_wb.m2r;
  assign wb_dest       = w_dest;

  // R5: an unknown opcode enters execute as a no-op
  assert_unknown_nop_R5: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_RTYPE && opcode != OPC_LOAD && opcode != OPC_STORE &&
     opcode != OPC_BEQ) |=> (!ex_dst_sel && !ex_alu_imm && ex_alu_op == '0));
endmodule

// File: tb/pipe_ctrl_chain_test.sv
module pipe_ctrl_chain_test;
  logic       clk = 1'b0;
  logic       rst, stall, flush, alu_zero;
  logic [5:0] opcode;
  logic [4:0] rt_idx, rd_idx;
  logic       ex_dst_sel, ex_alu_imm, mem_branch, mem_read, mem_write, mem_pcsrc;
  logic [1:0] ex_alu_op;
  logic [4:0] mem_dest, wb_dest;
  logic       wb_reg_write, wb_mem_to_reg;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  pipe_ctrl_chain uut (
    .clk(clk), .rst(rst), .opcode(opcode), .rt_idx(rt_idx), .rd_idx(rd_idx),
    .stall(stall), .flush(flush), .alu_zero(alu_zero),
    .ex_dst_sel(ex_dst_sel), .ex_alu_imm(ex_alu_imm), .ex_alu_op(ex_alu_op),
    .mem_branch(mem_branch), .mem_read(mem_read), .mem_write(mem_write),
    .mem_pcsrc(mem_pcsrc), .mem_dest(mem_dest),
    .wb_reg_write(wb_reg_write), .wb_mem_to_reg(wb_mem_to_reg), .wb_dest(wb_dest)
  );

  // reference model state: execute, memory, write-back slots
  int    e_ctl, e_rt, e_rd;      // e_ctl bits: 8 dst,7 imm,6:5 op,4 br,3 rd,2 wr,1 rwr,0 m2r
  string e_tag;
  int    m_ctl, m_dest, m_zero;  // m_ctl bits: 4 br,3 rd,2 wr,1 rwr,0 m2r
  string m_tag;
  int    w_ctl, w_dest;          // w_ctl bits: 1 rwr,0 m2r

  function automatic int decode(input int opc);
    case (opc)
      'h00: return 'b1_0_10_000_10; // R1
      'h23: return 'b0_1_00_010_11; // R2
      'h2B: return 'b0_1_00_001_00; // R3
      'h04: return 'b0_0_01_100_00; // R4
      default: return 0;            // R5
    endcase
  endfunction

  function automatic string opc_tag(input int opc);
    case (opc)
      'h00: return "R1";
      'h23: return "R2";
      'h2B: return "R3";
      'h04: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clock(input int r, input int opc, input int rt, input int rd,
                             input int st, input int fl, input int z);
    int sel;
    if (r != 0) begin
      e_ctl = 0; e_rt = 0; e_rd = 0; e_tag = "R11";
      m_ctl = 0; m_dest = 0; m_zero = 0; m_tag = "R11";
      w_ctl = 0; w_dest = 0;
      return;
    end
    w_ctl  = m_ctl & 3;
    w_dest = m_dest;
    if (fl != 0) begin
      m_ctl = 0; m_dest = 0; m_zero = 0; m_tag = "R10";
    end else begin
      sel    = (e_ctl >> 8) & 1;
      m_ctl  = e_ctl & 'h1F;
      m_dest = sel ? e_rd : e_rt;
      m_zero = z;
      m_tag  = e_tag;
    end
    if (fl != 0 || st != 0) begin
      e_ctl = 0; e_rt = 0; e_rd = 0;
      e_tag = (fl != 0) ? "R10" : "R9";
    end else begin
      e_ctl = decode(opc); e_rt = rt; e_rd = rd; e_tag = opc_tag(opc);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, "ex_dst_sel", ex_dst_sel, (e_ctl >> 8) & 1);
    chk(e_tag, "ex_alu_imm", ex_alu_imm, (e_ctl >> 7) & 1);
    chk(e_tag, "ex_alu_op",  ex_alu_op,  (e_ctl >> 5) & 3);
    chk("R6",  "mem_bundle", {mem_branch, mem_read, mem_write}, (m_ctl >> 2) & 7);
    chk("R7",  "mem_dest",   mem_dest, m_dest);
    chk("R8",  "mem_pcsrc",  mem_pcsrc, ((m_ctl >> 4) & 1) & m_zero);
    chk("R6",  "wb_bundle",  {wb_reg_write, wb_mem_to_reg}, w_ctl);
    chk("R7",  "wb_dest",    wb_dest, w_dest);
  endtask

  task automatic step(input int r, input int opc, input int rt, input int rd,
                      input int st, input int fl, input int z);
    rst = r[0]; opcode = opc[5:0]; rt_idx = rt[4:0]; rd_idx = rd[4:0];
    stall = st[0]; flush = fl[0]; alu_zero = z[0];
    @(posedge clk);
    @(negedge clk);
    model_clock(r, opc, rt, rd, st, fl, z);
    compare_all();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int opcs[8];
    opcs = '{'h00, 'h23, 'h2B, 'h04, 'h08, 'h3F, 'h02, 'h0D};
    rst = 1'b1; opcode = 6'h3F; rt_idx = 0; rd_idx = 0;
    stall = 0; flush = 0; alu_zero = 0;
    @(negedge clk);
    // R11: reset state
    for (int i = 0; i < 3; i++) step(1, 'h00, 5, 6, 0, 0, 1);
    // R1..R5 decode with distinct indices, R7 selection both ways
    step(0, 'h00, 3, 17, 0, 0, 0);
    step(0, 'h23, 9, 22, 0, 0, 1);
    step(0, 'h2B, 12, 1, 0, 0, 0);
    step(0, 'h04, 4, 30, 0, 0, 1);   // R8 taken (zero in execute of beq, next cycle)
    step(0, 'h04, 7, 8, 0, 0, 1);
    step(0, 'h08, 31, 31, 0, 0, 0);  // beq in execute with zero=0 -> not taken
    step(0, 'h3F, 2, 3, 0, 0, 0);
    step(0, 'h02, 2, 3, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 'h3F, 0, 0, 0, 0, 0);
    // R9: stall right behind a taken branch
    step(0, 'h04, 5, 5, 0, 0, 0);
    step(0, 'h00, 10, 11, 1, 0, 1);
    step(0, 'h23, 13, 14, 0, 0, 0);
    step(0, 'h00, 15, 16, 1, 0, 0);
    step(0, 'h00, 15, 16, 0, 0, 0);
    // R10: flush with a branch about to be taken and a load in flight
    step(0, 'h04, 1, 2, 0, 0, 0);
    step(0, 'h23, 3, 4, 0, 0, 1);
    step(0, 'h00, 6, 7, 0, 1, 1);
    step(0, 'h2B, 8, 9, 0, 0, 0);
    step(0, 'h04, 8, 9, 1, 1, 1);    // stall and flush together
    for (int i = 0; i < 4; i++) step(0, 'h00, i, i + 20, 0, 0, 0);
    // mixed pseudo-random traffic with one mid-stream reset
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step((i == 300) ? 1 : 0, opcs[lf[2:0]], lf[7:3], lf[12:8],
           (lf[15:13] == 3'd0) ? 1 : 0, (lf[15:13] == 3'd7) ? 1 : 0, lf[11] ^ lf[3]);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule